// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a finite-impulse-response filter that forms its output without any hardware multiplier. Each tap product is never formed on its own. The taps are split into groups of four. Each group owns a 16-entry table holding every possible sum of a subset of its four coefficients. The filter visits one bit position of the stored samples per clock, starting at the least significant bit. On each cycle the current bit of the four samples in a group addresses that group's table. The group words are summed, and a shift-right accumulator weighs each bit slice by its place value. The sign-bit slice is subtracted, so the result is exact two's-complement arithmetic. One output therefore costs one clock per sample bit.

The tables are built as a single long shift register, so a new coefficient set is loaded by shifting a precomputed image in one bit per clock. The filter never computes the table words from raw coefficients; the loader supplies them ready-made. A user presents a sample with a start strobe whenever the block is idle, waits for the one-cycle valid pulse, and reads the full-precision result.

Top module: `da_fir`

## Requirements
- R1: After reset, outValid is 0, dataOut is 0, the sample delay line is all zero and every table word is zero, so a frame run before any load yields 0.
- R2: A start pulse is accepted only when no frame is in progress and loadEn is low; acceptance pushes sampleIn into tap 0 of the delay line, moves every older sample one tap further, and clears dataOut to 0 on the following cycle.
- R3: An accepted frame steps through DW bit positions, one per un-suspended clock, least significant bit first; if the start is sampled at edge 0, outValid is high for exactly the one cycle that follows edge DW, and it is low at every other time.
- R4: When outValid is high, dataOut (AW bits, two's complement) equals the sum over taps k of coef[k] times x[k], where x[0] is the newest accepted sample and x[k] the one accepted k frames earlier; all values are signed, and the sign-bit slice carries weight minus 2^(DW-1).
- R5: A start pulse raised while a frame is in progress has no effect: neither the current result nor the delay line contents seen by later frames changes.
- R6: While loadEn is high, every table bit moves one place along a single chain and loadBit enters at chain position 0. After the last shift, the word of group g, entry e occupies chain bits [(g*16+e)*TW +: TW]. Address bit j of group g is the current bit of tap 4g+j, and the entry holds the sum of the coefficients of taps 4g+j whose bit j of e is 1.
- R7: A cycle with loadEn high suspends the filter: the bit counter and the accumulator hold, and a frame resumes where it stopped once loadEn falls, so outValid comes that many cycles later.
- R8: dataOut holds its value from the valid cycle until the next accepted start, including through table loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a frame with sampleIn |
| sampleIn | input | DW | New input sample, two's complement |
| loadEn | input | 1 | Shift one table bit in this cycle; suspends filtering |
| loadBit | input | 1 | Serial table-image bit |
| outValid | output | 1 | One-cycle pulse marking a finished result |
| dataOut | output | AW | Filter result, two's complement, full precision |

## Verification
The assertions assume that start and loadEn are driven only from the clean, reset-released interface. They also assume that loadEn stays low during reset, so the hold properties on dataOut begin from the cleared accumulator. The bench keeps to this by driving every input at the falling edge. It releases reset with all strobes low. It raises loadEn in the middle of a frame only to shift in the very same table image again, so the suspended frame still has a defined expected value. Starts raised during a busy frame and starts raised during a load are deliberate. They fall within the assumptions because the properties only tie acceptance to the idle, not-loading condition.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capture;  // accept sampleIn, clear accumulator
    logic step;     // process one bit slice
    logic last;     // this slice is the sign bit; frame ends here
  } daStrobe_t;

endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          loadEn,
  output daStrobe_t     stb,
  output logic [CW-1:0] bitIdx,
  output logic          busy
);

  logic [CW-1:0] bitCnt;
  logic          accept;
  logic          stepNow;
  logic          lastNow;

  assign accept  = start && !busy && !loadEn;
  assign stepNow = busy && !loadEn;
  assign lastNow = stepNow && (bitCnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      bitCnt <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      bitCnt <= '0;
    end else if (stepNow) begin
      if (lastNow) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.capture = accept;
    stb.step    = stepNow;
    stb.last    = lastNow;
  end

  assign bitIdx = bitCnt;

endmodule

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
  parameter int NGRP = 2,
  parameter int TW   = 18,
  localparam int ENTRIES = 16,
  localparam int CHAIN   = NGRP * ENTRIES * TW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   shiftEn,
  input  logic                   shiftIn,
  input  logic [NGRP*4-1:0]      addr,
  output logic [NGRP*TW-1:0]     words
);

  // All tables of all groups form one serial chain.
  logic [CHAIN-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
    end else if (shiftEn) begin
      chain <= {chain[CHAIN-2:0], shiftIn};
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_port
    logic [3:0] sel;
    assign sel = addr[g*4 +: 4];
    assign words[g*TW +: TW] = chain[(g*ENTRIES + int'(sel))*TW +: TW];
  end

endmodule

// File: rtl/da_fir_dp.sv
module da_fir_dp
  import da_fir_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int TW    = 18,
  localparam int NGRP = NTAPS / 4,
  localparam int SUMW = TW + $clog2(NGRP),
  localparam int AW   = SUMW + DW,
  localparam int CW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  daStrobe_t     stb,
  input  logic [CW-1:0] bitIdx,
  input  logic [DW-1:0] sampleIn,
  input  logic          loadEn,
  input  logic          loadBit,
  output logic          outValid,
  output logic [AW-1:0] dataOut
);

  logic [DW-1:0]          tapReg [NTAPS];
  logic [NGRP*4-1:0]      lutAddr;
  logic [NGRP*TW-1:0]     lutWords;
  logic signed [SUMW-1:0] sliceSum;
  logic signed [AW-1:0]   term;
  logic signed [AW-1:0]   acc;

  // Sample delay line: tap 0 is the newest sample.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NTAPS; k++) tapReg[k] <= '0;
    end else if (stb.capture) begin
      tapReg[0] <= sampleIn;
      for (int k = 1; k < NTAPS; k++) tapReg[k] <= tapReg[k-1];
    end
  end

  // Bit slice across the four taps of each group forms the table address.
  for (genvar g = 0; g < NGRP; g++) begin : g_addr
    for (genvar j = 0; j < 4; j++) begin : g_bit
      assign lutAddr[g*4 + j] = tapReg[g*4 + j][bitIdx];
    end
  end

  da_fir_lut #(
    .NGRP(NGRP),
    .TW  (TW)
  ) u_lut (
    .clk    (clk),
    .rstN   (rstN),
    .shiftEn(loadEn),
    .shiftIn(loadBit),
    .addr   (lutAddr),
    .words  (lutWords)
  );

  // Combine the group words of this slice.
  always_comb begin
    sliceSum = '0;
    for (int g = 0; g < NGRP; g++) begin
      sliceSum = sliceSum + SUMW'($signed(lutWords[g*TW +: TW]));
    end
  end

  assign term = AW'(sliceSum) <<< (DW - 1);

  // Shift-right accumulate; the sign slice is subtracted.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc      <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.last;
      if (stb.capture) begin
        acc <= '0;
      end else if (stb.step) begin
        acc <= (acc >>> 1) + (stb.last ? -term : term);
      end
    end
  end

  assign dataOut = acc;

endmodule

// File: rtl/da_fir.sv
module da_fir
  import da_fir_pkg::*;
#(
  parameter int NTAPS = 8,
  parameter int DW    = 16,
  parameter int TW    = 18,
  localparam int NGRP = NTAPS / 4,
  localparam int SUMW = TW + $clog2(NGRP),
  localparam int AW   = SUMW + DW,
  localparam int CW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [DW-1:0] sampleIn,
  input  logic          loadEn,
  input  logic          loadBit,
  output logic          outValid,
  output logic [AW-1:0] dataOut
);

  daStrobe_t     stb;
  logic [CW-1:0] bitIdx;
  logic          busy;

  da_fir_ctrl #(
    .DW(DW)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .loadEn(loadEn),
    .stb   (stb),
    .bitIdx(bitIdx),
    .busy  (busy)
  );

  da_fir_dp #(
    .NTAPS(NTAPS),
    .DW   (DW),
    .TW   (TW)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .bitIdx  (bitIdx),
    .sampleIn(sampleIn),
    .loadEn  (loadEn),
    .loadBit (loadBit),
    .outValid(outValid),
    .dataOut (dataOut)
  );

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int DW = 16,
  parameter int AW = 35,
  localparam int KW = $clog2(DW + 1) + 1
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          loadEn,
  input logic          busy,
  input logic          outValid,
  input logic [AW-1:0] dataOut
);

  // Counts un-suspended busy cycles since the last accepted start.
  logic [KW-1:0] cycCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
    end else if (start && !busy && !loadEn) begin
      cycCnt <= '0;
    end else if (busy && !loadEn) begin
      cycCnt <= cycCnt + 1'b1;
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !loadEn) |=> (busy && dataOut == '0));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3
  valid_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (cycCnt == KW'(DW) && !busy));

  // R7
  load_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> $stable(dataOut));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(dataOut));

endmodule

bind da_fir da_fir_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/da_fir_tb.sv
module da_fir_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NTAPS = 8;
  localparam int DW    = 16;
  localparam int TW    = 18;
  localparam int NGRP  = NTAPS / 4;
  localparam int AW    = TW + $clog2(NGRP) + DW;
  localparam int L     = NGRP * 16 * TW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] sampleIn = '0;
  logic          loadEn = 1'b0;
  logic          loadBit = 1'b0;
  logic          outValid;
  logic [AW-1:0] dataOut;

  int nRun = 0;
  int nFail = 0;
  int coef [NTAPS];
  int hist [NTAPS];
  logic [31:0] lf = 32'h1ACE_B00C;

  da_fir #(.NTAPS(NTAPS), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .sampleIn(sampleIn),
    .loadEn(loadEn), .loadBit(loadBit), .outValid(outValid), .dataOut(dataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  task automatic check(input string tag, input longint got, input longint exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic longint expY();
    longint s = 0;
    for (int k = 0; k < NTAPS; k++) s += longint'(coef[k]) * longint'(hist[k]);
    return s;
  endfunction

  function automatic longint outVal();
    return longint'($signed(dataOut));
  endfunction

  function automatic int nextRand();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return int'($signed(lf[15:0]));
  endfunction

  // R6: image built from coef and shifted in, highest chain bit first.
  task automatic loadTable(input bit pokeStart);
    logic [L-1:0] img;
    img = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int e = 0; e < 16; e++) begin
        longint w = 0;
        for (int j = 0; j < 4; j++) if (e[j]) w += longint'(coef[4*g + j]);
        img[(g*16 + e)*TW +: TW] = w[TW-1:0];
      end
    end
    for (int i = L - 1; i >= 0; i--) begin
      loadEn  = 1'b1;
      loadBit = img[i];
      if (pokeStart) begin
        start    = 1'b1;
        sampleIn = 16'h4321;
      end
      @(negedge clk);
    end
    loadEn  = 1'b0;
    loadBit = 1'b0;
    start   = 1'b0;
  endtask

  task automatic frame(input int x, input int pokeAt, input int pauseAt);
    bit early = 1'b0;
    longint held;
    start    = 1'b1;
    sampleIn = x[DW-1:0];
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= DW; k++) begin
      if (pokeAt == k) begin
        start    = 1'b1;
        sampleIn = ~sampleIn;
      end
      if (pauseAt == k) loadTable(1'b0);
      @(negedge clk);
      start = 1'b0;
      if (k < DW && outValid) early = 1'b1;
    end
    check("R3 no early valid", longint'(early), 0);
    check("R3 valid after DW edges", longint'(outValid), 1);
    for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    check("R4 result", outVal(), expY());
    held = outVal();
    @(negedge clk);
    check("R3 single valid cycle", longint'(outValid), 0);
    check("R8 result held", outVal(), held);
  endtask

  initial begin
    longint held;
    for (int k = 0; k < NTAPS; k++) begin
      coef[k] = 0;
      hist[k] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 valid low after reset", longint'(outValid), 0);
    check("R1 data zero after reset", outVal(), 0);
    // R1: tables are zero, so the result is zero.
    frame(1234, -1, -1);

    coef = '{3, -7, 100, -2500, 32767, -32768, 1, 12345};
    held = outVal();
    loadTable(1'b0);
    check("R8 hold across load", outVal(), held);
    check("R7 no valid during load", longint'(outValid), 0);

    // R4: impulse sweeps over every tap position.
    frame(1, -1, -1);
    for (int k = 1; k < NTAPS; k++) frame(0, -1, -1);
    frame(-32768, -1, -1);
    for (int k = 1; k < NTAPS; k++) frame(0, -1, -1);
    for (int k = 0; k < NTAPS; k++) frame(32767, -1, -1);
    for (int k = 0; k < NTAPS; k++) frame(-32768, -1, -1);
    for (int k = 0; k < 30; k++) frame(nextRand(), -1, -1);

    // R5: start while busy is ignored.
    frame(500, 7, -1);
    frame(-3, 1, -1);
    frame(77, -1, -1);

    // R7: suspension mid-frame by reloading the same image.
    frame(-777, -1, 5);
    frame(4096, -1, 1);

    // R2: starts raised during a load are not accepted.
    coef = '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768};
    held = outVal();
    loadTable(1'b1);
    @(negedge clk);
    check("R2 no frame from start during load", longint'(outValid), 0);
    check("R2 result untouched", outVal(), held);
    for (int k = 0; k < NTAPS; k++) frame(-32768, -1, -1);
    for (int k = 0; k < NTAPS; k++) frame(32767, -1, -1);

    for (int k = 0; k < NTAPS; k++) coef[k] = nextRand();
    loadTable(1'b0);
    for (int k = 0; k < 30; k++) frame(nextRand(), (k % 5 == 0) ? 9 : -1, (k % 7 == 3) ? 12 : -1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule